// File: doc/BRIEF.md
# Chain-Sequenced Microprogram Controller

This block is a small microprogrammed control unit. A 4-bit address counter points into a fixed control store that holds an eleven-word example program. Each control word carries five microoperation bits, a chain-exit flag and a program-end flag. Inside a straight run of microinstructions (a chain) the counter simply steps by one. At the word that closes a chain, a combinational transition circuit takes the full current address and the three condition inputs, and picks the entry address of the next chain. The counter then loads that address.

The two clock edges split the work. The counter and the sequencing state machine move on the rising edge. The control word is registered on the falling edge, so a fresh word is ready before the next rising edge needs it. The sequencing machine has three states. SEQ_BOOT waits for the first fetch after reset. SEQ_RUN steps or loads the counter. SEQ_HALT freezes everything once the end-of-program word has been seen. The named transitions are: BOOT to RUN on the first fetch, RUN to RUN on a step or a load, RUN to HALT on the end flag, and HALT to HALT until reset.

Top module: `chain_mpc`

## Requirements
- R1: While `rst` is high, `uop_o` is all zeros, `done_o` is low, and the counter is held at address 0000.
- R2: The control words at addresses 0 to 10 (bit 6 = chain exit, bits 5..1 = microoperations y1..y5, bit 0 = program end) are 0110000, 1001100, 0011000, 0100100, 0000010, 0101000, 1011011, 0110000, 1101010, 0001100, 1101000. `uop_o[4]` carries y1 and `uop_o[0]` carries y5. The word at the current address is registered on the falling clock edge.
- R3: After reset is released, the word at address 0 is presented for two clock periods (one in SEQ_BOOT, one in SEQ_RUN) before the counter first advances.
- R4: In SEQ_RUN, when the current word has neither the exit flag nor the end flag, the counter increments by one on the rising edge.
- R5: At the exit word at address 0001 the next address is 0010 if x1 (`cond_i[0]`) is 1. Otherwise it is 0111 if x2 (`cond_i[1]`) is 1, and 1001 if both are 0.
- R6: At the exit words at 1000 and 1010 the next address is 0101 if x3 (`cond_i[2]`) is 1, and 0000 otherwise.
- R7: When the current word has the end flag (address 0110), the controller enters SEQ_HALT on the next rising edge. From then on `done_o` is high and `uop_o` and the counter stay fixed until reset.
- R8: `cond_i` has no effect on the sequence except in the cycle where an exit word (other than the end word) is current.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counter on rising edge, control word on falling edge |
| rst | input | 1 | Asynchronous active-high reset |
| cond_i | input | 3 | Logic conditions: bit 0 = x1, bit 1 = x2, bit 2 = x3 |
| uop_o | output | 5 | Microoperations y1..y5 of the current control word |
| done_o | output | 1 | High while the halted state is held |

## Verification
Five condition schedules are used, each applied at the successive chain exits. Together they take every exit branch: the direct x1 path to the end chain, the x2 path that leaves through 1000, and the path with both conditions false that leaves through 1010. Two of the schedules return to address 0000 and run the program a second time, which shows that a loop back re-enters the first chain correctly. On every non-exit cycle and on every halted cycle, the condition inputs are driven with a changing noise pattern. Any leak of `cond_i` outside exit cycles would therefore move the microoperation stream away from the model.

// File: rtl/chain_mpc_pkg.sv
package chain_mpc_pkg;

    typedef enum logic [1:0] {
        SEQ_BOOT = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HALT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/chain_mpc_store.sv
// Fixed control store: word = {exit, y1..y5, end}.
module chain_mpc_store #(
    parameter int ADDR_W = 4,
    parameter int UOP_W  = 5,
    localparam int CW_W  = UOP_W + 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CW_W-1:0]   word
);
    always_comb begin
        unique case (int'(addr))
            0:       word = CW_W'(7'b0110000);
            1:       word = CW_W'(7'b1001100);
            2:       word = CW_W'(7'b0011000);
            3:       word = CW_W'(7'b0100100);
            4:       word = CW_W'(7'b0000010);
            5:       word = CW_W'(7'b0101000);
            6:       word = CW_W'(7'b1011011);
            7:       word = CW_W'(7'b0110000);
            8:       word = CW_W'(7'b1101010);
            9:       word = CW_W'(7'b0001100);
            10:      word = CW_W'(7'b1101000);
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/chain_mpc_branch.sv
// Transition circuit: full address plus conditions to next chain entry.
module chain_mpc_branch #(
    parameter int ADDR_W = 4,
    parameter int COND_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [COND_W-1:0] cond,
    output logic [ADDR_W-1:0] entry
);
    always_comb begin
        unique case (int'(addr))
            1: begin
                if (cond[0])      entry = ADDR_W'(2);
                else if (cond[1]) entry = ADDR_W'(7);
                else              entry = ADDR_W'(9);
            end
            8, 10:   entry = cond[2] ? ADDR_W'(5) : ADDR_W'(0);
            default: entry = '0;
        endcase
    end
endmodule

// File: rtl/chain_mpc_seq.sv
// Sequencing state machine and address counter (rising edge).
module chain_mpc_seq
    import chain_mpc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetched,
    input  logic              last,
    input  logic              stop,
    input  logic [ADDR_W-1:0] entry,
    output logic [ADDR_W-1:0] addr,
    output seq_state_e        state
);
    seq_state_e        state_d;
    logic [ADDR_W-1:0] addr_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= SEQ_BOOT;
            addr  <= '0;
        end else begin
            state <= state_d;
            addr  <= addr_d;
        end
    end

    always_comb begin
        state_d = state;
        addr_d  = addr;
        unique case (state)
            SEQ_BOOT: begin
                if (fetched) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (stop)      state_d = SEQ_HALT;
                else if (last) addr_d  = entry;
                else           addr_d  = addr + ADDR_W'(1);
            end
            SEQ_HALT: begin
                state_d = SEQ_HALT;
            end
            default: state_d = SEQ_BOOT;
        endcase
    end
endmodule

// File: rtl/chain_mpc.sv
module chain_mpc
    import chain_mpc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int UOP_W  = 5,
    parameter int COND_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond_i,
    output logic [UOP_W-1:0]  uop_o,
    output logic              done_o
);
    localparam int CW_W = UOP_W + 2;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] entry;
    logic [CW_W-1:0]   store_word;
    logic [CW_W-1:0]   cw_q;
    logic              fetched_q;
    seq_state_e        state_q;
    logic              cw_last;
    logic              cw_stop;
    logic              running;

    chain_mpc_store #(.ADDR_W(ADDR_W), .UOP_W(UOP_W)) u_store (
        .addr (addr_q),
        .word (store_word)
    );

    chain_mpc_branch #(.ADDR_W(ADDR_W), .COND_W(COND_W)) u_branch (
        .addr  (addr_q),
        .cond  (cond_i),
        .entry (entry)
    );

    chain_mpc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .fetched (fetched_q),
        .last    (cw_last),
        .stop    (cw_stop),
        .entry   (entry),
        .addr    (addr_q),
        .state   (state_q)
    );

    // Control word register on the falling edge; frozen once halted.
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            cw_q      <= '0;
            fetched_q <= 1'b0;
        end else if (state_q != SEQ_HALT) begin
            cw_q      <= store_word;
            fetched_q <= 1'b1;
        end
    end

    assign cw_last = cw_q[CW_W-1];
    assign cw_stop = cw_q[0];
    assign running = (state_q == SEQ_RUN);

    always_comb begin
        uop_o  = cw_q[CW_W-2:1];
        done_o = (state_q == SEQ_HALT);
    end
endmodule

// File: rtl/chain_mpc_chk.sv
module chain_mpc_chk #(
    parameter int ADDR_W = 4,
    parameter int UOP_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              running,
    input logic              last,
    input logic              stop,
    input logic [ADDR_W-1:0] addr,
    input logic [UOP_W-1:0]  uop_o,
    input logic              done_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |-> (uop_o == '0 && !done_o && addr == '0));

    assert_addr_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(addr) <= 10);

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (running && !last && !stop) |=> (addr == $past(addr) + ADDR_W'(1)));

    // Exits land on a chain entry only (R5, R6).
    assert_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (running && last && !stop) |=>
            (addr == 0 || addr == 2 || addr == 5 || addr == 7 || addr == 9));

    assert_halt_enter_R7: assert property (@(posedge clk) disable iff (rst)
        (running && stop) |=> done_o);

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && $stable(addr) && $stable(uop_o)));
endmodule

bind chain_mpc chain_mpc_chk #(.ADDR_W(4), .UOP_W(5)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .running (running),
    .last    (cw_last),
    .stop    (cw_stop),
    .addr    (addr_q),
    .uop_o   (uop_o),
    .done_o  (done_o)
);

// File: tb/chain_mpc_test.sv
module chain_mpc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [2:0] cond_i = '0;
    logic [4:0] uop_o;
    logic       done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [4:0] q_uop[$];
    logic       q_done[$];
    string      q_tag[$];

    chain_mpc uut (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond_i),
        .uop_o  (uop_o),
        .done_o (done_o)
    );

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Model of the program (R2): {exit, y1..y5, end}
    function automatic logic [6:0] model_word(int a);
        case (a)
            0: return 7'b0110000;   1: return 7'b1001100;
            2: return 7'b0011000;   3: return 7'b0100100;
            4: return 7'b0000010;   5: return 7'b0101000;
            6: return 7'b1011011;   7: return 7'b0110000;
            8: return 7'b1101010;   9: return 7'b0001100;
            10: return 7'b1101000;
            default: return 7'b0;
        endcase
    endfunction

    function automatic int model_next(int a, logic [2:0] x);
        if (a == 1) begin
            if (x[0]) return 2;
            if (x[1]) return 7;
            return 9;
        end
        if (x[2]) return 5;
        return 0;
    endfunction

    task automatic check(string tag, logic [4:0] au, logic ad, logic [4:0] eu, logic ed);
        n_checks = n_checks + 1;
        if (au !== eu || ad !== ed) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual uop=%b done=%b expected uop=%b done=%b",
                     tag, au, ad, eu, ed);
        end
    endtask

    // Monitor: pops expectations after the falling-edge update.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_uop.size() > 0) begin
                check(q_tag.pop_front(), uop_o, done_o, q_uop.pop_front(), q_done.pop_front());
            end
        end
    end

    // Driver: reset, then walk the model in lockstep, one exit condition per exit.
    task automatic run_program(logic [2:0] sched[], int salt);
        int    maddr = 0;
        bit    mboot = 1'b1;
        bit    mhalt = 1'b0;
        int    k = 0;
        int    halted = 0;
        int    steps = 0;
        string tag = "R3";
        logic [6:0] w;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check("R1", uop_o, done_o, 5'b0, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
        while (halted < 4 && steps < 200) begin
            @(negedge clk); #1;
            steps++;
            w = model_word(maddr);
            q_uop.push_back(w[5:1]);
            q_done.push_back(mhalt);
            q_tag.push_back(tag);
            if (!mboot && !mhalt && w[6] && !w[0]) begin
                cond_i = sched[k];
                tag = (maddr == 1) ? "R5" : "R6";
                maddr = model_next(maddr, sched[k]);
                k++;
            end else begin
                // Noise on non-exit cycles (R8).
                cond_i = 3'((steps * 5 + salt) ^ (steps >> 1));
                if (mboot) begin
                    mboot = 1'b0;
                    tag = "R3";
                end else if (mhalt) begin
                    halted++;
                    tag = "R7 R8";
                end else if (w[0]) begin
                    mhalt = 1'b1;
                    tag = "R7";
                end else begin
                    maddr = maddr + 1;
                    tag = "R4 R8";
                end
            end
        end
        if (steps >= 200) begin
            n_fail = n_fail + 1;
            $display("FAIL R7: actual no halt after %0d steps expected halt", steps);
        end
        @(negedge clk); #3;
    endtask

    initial begin
        #1 rst = 1'b1;
        run_program('{3'b001}, 1);                        // x1 path
        run_program('{3'b010, 3'b100}, 2);                // x2 path, x3 -> 0101
        run_program('{3'b000, 3'b100}, 3);                // both false, exit 1010
        run_program('{3'b010, 3'b000, 3'b001}, 4);        // exit 1000 loops to 0000
        run_program('{3'b000, 3'b011, 3'b010, 3'b111}, 5); // 1010 -> 0000 -> 1000
        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule